// File: doc/BRIEF.md
# Dual-Channel Parallel Port Adapter

This block hangs off a byte-wide host bus and gives two independent 8-bit parallel ports, A and B. Each pin can be set as an input or an output. Each channel also has two handshake lines. Line 1 is an edge-sensitive interrupt input. Line 2 can be an edge-sensitive interrupt input, a handshake output, or a plain output set by software.

The host reaches six registers per device through four addresses. Register-select bit 1 picks the channel and bit 0 picks the control register. At the other address, control bit 2 chooses between the direction register and the data register. A transfer completes when the enable strobe falls while all three chip selects are asserted. Read data appears on a separate output vector, together with an output enable. Each channel has an active-low interrupt request. The request is asserted while a latched line event has its enable bit set. Both line inputs of each channel pass through a two-flop synchronizer before edge detection.

Top module: `dual_port_adapter`

## Requirements
- R1: After reset every control, direction and data register reads 0, no port pin or line-2 output is enabled, and both interrupt requests are high.
- R2: reg_sel 00 reaches channel A and 10 reaches channel B. At these addresses, control bit 2 = 0 reaches the direction register and control bit 2 = 1 reaches the data register. reg_sel 01 and 11 reach control A and control B.
- R3: A direction bit of 1 enables that port pin as an output carrying the data-register bit. A direction bit of 0 leaves the pin as an input.
- R4: A data-register read returns the pin value for input bits and the register value for output bits.
- R5: Control bits 5..0 read back as written. Bit 7 is the line-1 event flag and bit 6 is the line-2 event flag. Writes never change bits 7 and 6.
- R6: Line 1 sets flag bit 7 on a falling edge when control bit 1 = 0, and on a rising edge when control bit 1 = 1. The flag sets even when enable bit 0 is clear. The request goes low while the flag and bit 0 are both set.
- R7: With control bit 5 = 0, line 2 is an input. Bit 4 selects the edge (0 falling, 1 rising) that sets flag bit 6. The request goes low while flag 6 and bit 3 are both set.
- R8: With control bits 5:4 = 11, line 2 is an enabled output equal to control bit 3.
- R9: Channel A with bits 5:4 = 10 drives line 2 low after a host read of its data register. With bit 3 = 0 the line returns high when the line-1 flag sets. With bit 3 = 1 it returns high at the next enable falling edge.
- R10: Channel B with bits 5:4 = 10 drives line 2 low after a host write of its data register, and uses the same return rule as R9.
- R11: A data-register read clears both flags of that channel. A flag-setting edge in the same cycle as that read wins, and the flag stays set.
- R12: Without full chip selection (cs_hi0=1, cs_hi1=1, cs_lo_n=0), the read-data enable stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cs_hi0_i | input | 1 | Chip select, active high |
| cs_hi1_i | input | 1 | Chip select, active high |
| cs_lo_n_i | input | 1 | Chip select, active low |
| reg_sel_i | input | 2 | Register select |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| en_i | input | 1 | Transfer strobe, acts on falling edge |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data |
| dat_oe_o | output | 1 | Read data enable |
| irq_a_n_o | output | 1 | Channel A interrupt request, active low |
| irq_b_n_o | output | 1 | Channel B interrupt request, active low |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A pin outputs |
| pa_oe_o | output | 8 | Port A pin output enables |
| pa_l1_i | input | 1 | Channel A line 1 |
| pa_l2_i | input | 1 | Channel A line 2 input |
| pa_l2_o | output | 1 | Channel A line 2 output |
| pa_l2_oe_o | output | 1 | Channel A line 2 output enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B pin outputs |
| pb_oe_o | output | 8 | Port B pin output enables |
| pb_l1_i | input | 1 | Channel B line 1 |
| pb_l2_i | input | 1 | Channel B line 2 input |
| pb_l2_o | output | 1 | Channel B line 2 output |
| pb_l2_oe_o | output | 1 | Channel B line 2 output enable |

## Verification
Two functions can land in the same clock edge. One is the setting of a line-1 flag by a synchronized edge. The other is the clearing of that flag by a host read of the data register. The bench provokes the collision by raising the line exactly two falling clock edges before it drops the enable strobe of a data read, so that the detected edge and the access share one cycle. It then judges the outcome by reading the control register: bit 7 must still be set. A second data read must then clear it.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  // line-2 operating mode, decoded from control bits 5:4
  typedef enum logic [1:0] {
    L2_INPUT  = 2'b00,
    L2_HSHAKE = 2'b10,
    L2_MANUAL = 2'b11
  } l2_mode_e;

  function automatic l2_mode_e l2_mode(input logic b5, input logic b4);
    if (!b5) return L2_INPUT;
    return b4 ? L2_MANUAL : L2_HSHAKE;
  endfunction

  // request is active while a latched event has its enable set
  function automatic logic irq_req(input logic [5:0] cr, input logic fl1, input logic fl2);
    return (fl1 & cr[0]) | (fl2 & cr[3] & ~cr[5]);
  endfunction
endpackage

// File: rtl/dpa_sync_edge.sv
module dpa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R6
  no_double_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dpa_channel.sv
module dpa_channel #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HS_ON_WRITE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_fall_i,
  input  logic         acc_i,
  input  logic         rd_i,
  input  logic         ctl_sel_i,
  input  logic [W-1:0] wdat_i,
  output logic [W-1:0] rdat_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  input  logic         l1_i,
  input  logic         l2_i,
  output logic         l2_o,
  output logic         l2_oe_o,
  output logic         irq_n_o
);
  import dpa_pkg::*;

  function automatic logic [W-1:0] merge_pins(input logic [W-1:0] pins,
                                              input logic [W-1:0] outv,
                                              input logic [W-1:0] dir);
    return (pins & ~dir) | (outv & dir);
  endfunction

  logic [W-1:0] ddr_q, out_q;
  logic [5:0]   cr_q;
  logic         fl1_q, fl2_q, hs_q;
  logic         l1_rise, l1_fall, l2_rise, l2_fall;

  dpa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_l1 (
    .clk_i, .rst_ni, .d_i(l1_i), .rise_o(l1_rise), .fall_o(l1_fall));
  dpa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_l2 (
    .clk_i, .rst_ni, .d_i(l2_i), .rise_o(l2_rise), .fall_o(l2_fall));

  // named internal events
  logic     ev1, ev2, data_sel, data_rd, data_wr, ddr_wr, ctl_wr, hs_trig, hs_rel;
  l2_mode_e mode;

  assign mode     = l2_mode(cr_q[5], cr_q[4]);
  assign ev1      = cr_q[1] ? l1_rise : l1_fall;
  assign ev2      = ~cr_q[5] & (cr_q[4] ? l2_rise : l2_fall);
  assign data_sel = ~ctl_sel_i & cr_q[2];
  assign data_rd  = acc_i &  rd_i & data_sel;
  assign data_wr  = acc_i & ~rd_i & data_sel;
  assign ddr_wr   = acc_i & ~rd_i & ~ctl_sel_i & ~cr_q[2];
  assign ctl_wr   = acc_i & ~rd_i & ctl_sel_i;
  assign hs_trig  = HS_ON_WRITE ? data_wr : data_rd;
  assign hs_rel   = cr_q[3] ? en_fall_i : ev1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddr_q <= '0;
      out_q <= '0;
      cr_q  <= '0;
      fl1_q <= 1'b0;
      fl2_q <= 1'b0;
      hs_q  <= 1'b1;
    end else begin
      if (ddr_wr)  ddr_q <= wdat_i;
      if (data_wr) out_q <= wdat_i;
      if (ctl_wr)  cr_q  <= wdat_i[5:0];
      if (ev1)          fl1_q <= 1'b1;
      else if (data_rd) fl1_q <= 1'b0;
      if (ev2)          fl2_q <= 1'b1;
      else if (data_rd) fl2_q <= 1'b0;
      if (hs_trig)      hs_q  <= 1'b0;
      else if (hs_rel)  hs_q  <= 1'b1;
    end
  end

  always_comb begin
    if (ctl_sel_i)     rdat_o = {fl1_q, fl2_q, cr_q};
    else if (cr_q[2])  rdat_o = merge_pins(pin_i, out_q, ddr_q);
    else               rdat_o = ddr_q;
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ddr_q;
  assign l2_oe_o  = cr_q[5];
  assign l2_o     = (mode == L2_MANUAL) ? cr_q[3] : hs_q;
  assign irq_n_o  = ~irq_req(cr_q, fl1_q, fl2_q);

  // R6
  flag_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev1 |=> fl1_q);
  // R11
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !ev1) |=> !fl1_q);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_o |-> (fl1_q || fl2_q));
  // R5
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(cr_q));
  // R9
  hs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_trig |=> !hs_q);
endmodule

// File: rtl/dual_port_adapter.sv
module dual_port_adapter #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_hi0_i,
  input  logic         cs_hi1_i,
  input  logic         cs_lo_n_i,
  input  logic [1:0]   reg_sel_i,
  input  logic         rd_wr_i,
  input  logic         en_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] dat_o,
  output logic         dat_oe_o,
  output logic         irq_a_n_o,
  output logic         irq_b_n_o,
  input  logic [W-1:0] pa_i,
  output logic [W-1:0] pa_o,
  output logic [W-1:0] pa_oe_o,
  input  logic         pa_l1_i,
  input  logic         pa_l2_i,
  output logic         pa_l2_o,
  output logic         pa_l2_oe_o,
  input  logic [W-1:0] pb_i,
  output logic [W-1:0] pb_o,
  output logic [W-1:0] pb_oe_o,
  input  logic         pb_l1_i,
  input  logic         pb_l2_i,
  output logic         pb_l2_o,
  output logic         pb_l2_oe_o
);
  localparam int NCH = 2;

  logic en_q, en_fall, sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign sel     = cs_hi0_i & cs_hi1_i & ~cs_lo_n_i;
  assign en_fall = en_q & ~en_i;

  logic [W-1:0] pin_in [NCH], pin_out [NCH], pin_oe [NCH], rdat [NCH];
  logic         l1_in [NCH], l2_in [NCH], l2_out [NCH], l2_oe [NCH], irq_n [NCH];

  assign pin_in[0] = pa_i;    assign pin_in[1] = pb_i;
  assign l1_in[0]  = pa_l1_i; assign l1_in[1]  = pb_l1_i;
  assign l2_in[0]  = pa_l2_i; assign l2_in[1]  = pb_l2_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic acc;
    assign acc = en_fall & sel & (reg_sel_i[1] == g[0]);
    dpa_channel #(
      .W(W), .SYNC_STAGES(SYNC_STAGES), .HS_ON_WRITE(g == 1)
    ) u_ch (
      .clk_i, .rst_ni,
      .en_fall_i(en_fall),
      .acc_i(acc),
      .rd_i(rd_wr_i),
      .ctl_sel_i(reg_sel_i[0]),
      .wdat_i(dat_i),
      .rdat_o(rdat[g]),
      .pin_i(pin_in[g]),
      .pin_o(pin_out[g]),
      .pin_oe_o(pin_oe[g]),
      .l1_i(l1_in[g]),
      .l2_i(l2_in[g]),
      .l2_o(l2_out[g]),
      .l2_oe_o(l2_oe[g]),
      .irq_n_o(irq_n[g])
    );
  end

  assign dat_o      = reg_sel_i[1] ? rdat[1] : rdat[0];
  assign dat_oe_o   = sel & rd_wr_i;
  assign pa_o       = pin_out[0]; assign pb_o       = pin_out[1];
  assign pa_oe_o    = pin_oe[0];  assign pb_oe_o    = pin_oe[1];
  assign pa_l2_o    = l2_out[0];  assign pb_l2_o    = l2_out[1];
  assign pa_l2_oe_o = l2_oe[0];   assign pb_l2_oe_o = l2_oe[1];
  assign irq_a_n_o  = irq_n[0];   assign irq_b_n_o  = irq_n[1];

  // R12
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_hi0_i && cs_hi1_i && !cs_lo_n_i) |-> !dat_oe_o);
  // R1
  reset_irq_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_a_n_o && irq_b_n_o && pa_oe_o == '0 && pb_oe_o == '0));
endmodule

// File: tb/test_dual_port_adapter.sv
module test_dual_port_adapter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_hi0 = 0, cs_hi1 = 0, cs_lo_n = 1, rd_wr = 1, en = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] dat_i = 0, dat_o, pa_i = 0, pb_i = 0, pa_o, pb_o, pa_oe, pb_oe;
  logic dat_oe, irq_a_n, irq_b_n;
  logic pa_l1 = 0, pa_l2 = 0, pb_l1 = 0, pb_l2 = 0;
  logic pa_l2_o, pa_l2_oe, pb_l2_o, pb_l2_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_port_adapter i_dual_port_adapter (
    .clk_i(clk), .rst_ni(rst_n), .cs_hi0_i(cs_hi0), .cs_hi1_i(cs_hi1),
    .cs_lo_n_i(cs_lo_n), .reg_sel_i(reg_sel), .rd_wr_i(rd_wr), .en_i(en),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe),
    .irq_a_n_o(irq_a_n), .irq_b_n_o(irq_b_n),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe), .pa_l1_i(pa_l1), .pa_l2_i(pa_l2),
    .pa_l2_o(pa_l2_o), .pa_l2_oe_o(pa_l2_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe), .pb_l1_i(pb_l1), .pb_l2_i(pb_l2),
    .pb_l2_o(pb_l2_o), .pb_l2_oe_o(pb_l2_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cs = {hi0, hi1, lo_n}; full selection is 3'b110
  task automatic bus_wr(input logic [1:0] rs, input logic [7:0] d,
                        input logic [2:0] cs = 3'b110);
    @(negedge clk);
    {cs_hi0, cs_hi1, cs_lo_n} = cs; reg_sel = rs; rd_wr = 0; dat_i = d; en = 1;
    @(negedge clk); en = 0;
    @(negedge clk); {cs_hi0, cs_hi1, cs_lo_n} = 3'b001; rd_wr = 1;
  endtask

  task automatic bus_rd(input logic [1:0] rs, output logic [7:0] d,
                        input logic [2:0] cs = 3'b110);
    @(negedge clk);
    {cs_hi0, cs_hi1, cs_lo_n} = cs; reg_sel = rs; rd_wr = 1; en = 1;
    @(negedge clk); en = 0; #1 d = dat_o;
    @(negedge clk); {cs_hi0, cs_hi1, cs_lo_n} = 3'b001;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 irq", {6'd0, irq_a_n, irq_b_n}, 8'h03);
    chk("R1 l2_oe", {6'd0, pa_l2_oe, pb_l2_oe}, 8'h00);
    bus_rd(2'b01, v); chk("R1 ctl A", v, 8'h00);
    bus_rd(2'b11, v); chk("R1 ctl B", v, 8'h00);
    bus_rd(2'b00, v); chk("R1 ddr A", v, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    bus_wr(2'b00, 8'h0F);           // direction A (bit 2 = 0)
    bus_wr(2'b01, 8'h04);           // select data register
    bus_wr(2'b00, 8'hA5);
    chk("R3 pa_o", pa_o, 8'hA5);
    chk("R3 pa_oe", pa_oe, 8'h0F);
    pa_i = 8'h30;
    bus_rd(2'b00, v); chk("R4 mixed read", v, 8'h35);
    bus_wr(2'b01, 8'h00);
    bus_rd(2'b00, v); chk("R2 ddr behind addr", v, 8'h0F);
    bus_wr(2'b10, 8'hF0);           // direction B
    chk("R2 pb_oe", pb_oe, 8'hF0);
    chk("R2 pa_oe kept", pa_oe, 8'h0F);
  endtask

  task automatic t_ctl();
    logic [7:0] v;
    bus_wr(2'b01, 8'hFF);
    bus_rd(2'b01, v); chk("R5 ctl rw", v, 8'h3F);
    bus_wr(2'b01, 8'h04);
  endtask

  task automatic t_line1();
    logic [7:0] v;
    pa_l1 = 1; settle();
    bus_rd(2'b01, v); chk("R6 wrong edge", v, 8'h04);
    pa_l1 = 0; settle();
    bus_rd(2'b01, v); chk("R6 flag no en", v, 8'h84);
    chk("R6 irq off", {7'd0, irq_a_n}, 8'h01);
    bus_wr(2'b01, 8'h05);
    chk("R6 irq on", {7'd0, irq_a_n}, 8'h00);
    bus_rd(2'b00, v);
    bus_rd(2'b01, v); chk("R11 cleared", v, 8'h05);
    chk("R11 irq released", {7'd0, irq_a_n}, 8'h01);
    bus_wr(2'b01, 8'h07);
    pa_l1 = 1; settle();
    bus_rd(2'b01, v); chk("R6 rising", v, 8'h87);
    bus_rd(2'b00, v);
  endtask

  task automatic t_line2();
    logic [7:0] v;
    bus_wr(2'b01, 8'h1C);
    pa_l2 = 1; settle();
    bus_rd(2'b01, v); chk("R7 flag6", v, 8'h5C);
    chk("R7 irq", {7'd0, irq_a_n}, 8'h00);
    bus_rd(2'b00, v);
    chk("R11 irq after read", {7'd0, irq_a_n}, 8'h01);
    pa_l2 = 0;
  endtask

  task automatic t_manual();
    bus_wr(2'b01, 8'h38);
    chk("R8 high", {6'd0, pa_l2_oe, pa_l2_o}, 8'h03);
    bus_wr(2'b01, 8'h30);
    chk("R8 low", {6'd0, pa_l2_oe, pa_l2_o}, 8'h02);
  endtask

  task automatic t_hs_a();
    logic [7:0] v;
    bus_wr(2'b01, 8'h2C);           // handshake, pulse return
    chk("R9 idle high", {7'd0, pa_l2_o}, 8'h01);
    bus_rd(2'b00, v);
    chk("R9 low after read", {7'd0, pa_l2_o}, 8'h00);
    bus_rd(2'b11, v, 3'b000);       // unselected strobe
    chk("R9 pulse end", {7'd0, pa_l2_o}, 8'h01);
    bus_wr(2'b01, 8'h24);           // return on line-1 flag, falling edge
    bus_rd(2'b00, v);
    chk("R9 held low", {7'd0, pa_l2_o}, 8'h00);
    bus_rd(2'b01, v);
    chk("R9 still low", {7'd0, pa_l2_o}, 8'h00);
    pa_l1 = 0; settle();
    chk("R9 flag release", {7'd0, pa_l2_o}, 8'h01);
  endtask

  task automatic t_hs_b();
    logic [7:0] v;
    bus_wr(2'b11, 8'h24);
    bus_rd(2'b10, v);
    chk("R10 read no effect", {7'd0, pb_l2_o}, 8'h01);
    bus_wr(2'b10, 8'h55);
    chk("R10 low after write", {7'd0, pb_l2_o}, 8'h00);
    pb_l1 = 1; settle(); pb_l1 = 0; settle();
    chk("R10 release", {7'd0, pb_l2_o}, 8'h01);
    bus_rd(2'b11, v); chk("R10 flag B", v, 8'hA4);
  endtask

  task automatic t_coincide();
    logic [7:0] v;
    bus_wr(2'b01, 8'h06);           // rising edge, data register
    bus_rd(2'b00, v);
    pa_l1 = 0; settle();
    @(negedge clk);
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b110; reg_sel = 2'b00; rd_wr = 1; en = 1;
    pa_l1 = 1;
    @(negedge clk);
    @(negedge clk); en = 0;
    @(negedge clk); {cs_hi0, cs_hi1, cs_lo_n} = 3'b001;
    settle();
    bus_rd(2'b01, v); chk("R11 set wins", v, 8'h86);
    bus_rd(2'b00, v);
    bus_rd(2'b01, v); chk("R11 later clear", v, 8'h06);
  endtask

  task automatic t_desel();
    logic [7:0] v;
    bus_wr(2'b01, 8'h3F, 3'b111);
    bus_wr(2'b01, 8'h3F, 3'b010);
    bus_wr(2'b01, 8'h3F, 3'b100);
    bus_rd(2'b01, v); chk("R12 no write", v, 8'h06);
    @(negedge clk);
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b111; rd_wr = 1; #1;
    chk("R12 dat_oe", {7'd0, dat_oe}, 8'h00);
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b110; #1;
    chk("R12 dat_oe sel", {7'd0, dat_oe}, 8'h01);
    {cs_hi0, cs_hi1, cs_lo_n} = 3'b001;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_ctl();
    t_line1();
    t_line2();
    t_manual();
    t_hs_a();
    t_hs_b();
    t_coincide();
    t_desel();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule